// File: doc/BRIEF.md
# Power-Up Configuration and Self-Test Sequencer

This block takes a serial-bus terminal from master clear to either on-line or off-line operation. Once the synchronised master clear releases, it reads a six-bit configuration word from host memory over a request/grant/acknowledge transfer. A strap input can skip that read, in which case every parameter takes its enabled default. The block then holds a self-test request until the test engine reports done. From the test verdict and the configuration word it decides whether the terminal is allowed onto the bus.

The block drives the terminal-active indicator, the active-low terminal-fail flag, the latched configuration bits and the per-channel transmitter enables. Configuration bit 5 means "go on-line regardless". When it is set, or when configuration was skipped, a failed self-test still raises the fail flag but does not keep the terminal off the bus.

Top module: `pwrup_cfg_seq`

## Requirements
- R1: `active` is 0 from master clear, through the configuration read, and during self-test; it can only become 1 after `bist_done` is seen.
- R2: `mclr_n` is active low and passes through a two-stage synchroniser. While it is low, or during the two clocks after it rises, the block holds its initial state: `active`=0, `rt_fail_n`=1, `cfg_bits`=0, no request.
- R3: With `autocfg_dis`=1 no configuration request is issued and `cfg_bits` loads 6'b111111 (every parameter enabled; bit 0..5 all 1, the protocol-select bit meaning the later protocol revision).
- R4: With `autocfg_dis`=0, `cfg_req` stays high until a clock sees `cfg_grant`=1. After that, the first clock with `cfg_ack_n`=0 captures `cfg_data`. A `cfg_ack_n`=0 that arrives before the grant is ignored.
- R5: Captured bits map one to one: `cfg_bits[i]` = `cfg_data[i]`, and 1 means enabled. Bit 5 is the always-go-on-line bit.
- R6: On the clock where `bist_done`=1 during self-test, the terminal goes on-line (`active`=1 from the next clock) if `bist_pass`=1 or `cfg_bits[5]`=1.
- R7: A self-test completing with `bist_pass`=0 drives `rt_fail_n` to 0 from the next clock. If `cfg_bits[5]`=0 as well, the terminal goes off-line and `active` stays 0.
- R8: The on-line and off-line outcomes, and `rt_fail_n`=0, persist until the next master clear; further `bist_done` pulses or handshake inputs have no effect.
- R9: `tx_en[c]` for every channel equals `active` AND NOT `tx_inhibit`, with no clock delay from `tx_inhibit`.
- R10: `bist_start` is 1 for exactly the cycles the sequencer spends waiting for the self-test result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mclr_n | input | 1 | Asynchronous master clear, active low |
| autocfg_dis | input | 1 | 1 skips the configuration read and uses defaults |
| cfg_req | output | 1 | Request for the configuration read transfer |
| cfg_grant | input | 1 | Transfer grant from the host |
| cfg_ack_n | input | 1 | Transfer acknowledge, active low; data valid while low |
| cfg_data | input | 6 | Configuration word bits 5..0 |
| bist_start | output | 1 | Self-test request, held until done |
| bist_done | input | 1 | Self-test finished |
| bist_pass | input | 1 | Self-test result, valid with done |
| tx_inhibit | input | 1 | 1 shuts down the transmitters of every channel |
| active | output | 1 | Terminal on-line |
| rt_fail_n | output | 1 | Terminal failure flag, active low |
| cfg_bits | output | 6 | Latched configuration parameters |
| tx_en | output | 2 | Transmitter enable per channel |

## Verification
The hardest outcome to reach is the off-line state. It needs configuration enabled, a captured word with bit 5 clear, and a failing self-test, all in one power-up. A close second is proving that an early acknowledge and late self-test pulses are ignored. The bench walks the handshake itself. It pulls `cfg_ack_n` low a cycle before granting, then acknowledges with a chosen word and answers the self-test request with a chosen verdict. After the decision it sends a second `bist_done` with the opposite verdict. A behavioural model compares every output on every clock, so the steady off-line state and the unchanged fail flag are checked directly at the ports.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_CFG_REQ = 3'd1,
    ST_CFG_ACK = 3'd2,
    ST_BIST    = 3'd3,
    ST_ONLINE  = 3'd4,
    ST_OFFLINE = 3'd5
  } seq_state_t;
endpackage

// File: rtl/pwr_sync2.sv
module pwr_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic async_n,
  output logic rst
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], async_n};
  end

  assign rst = ~chain[STAGES-1];
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int CFG_W      = 6,
  parameter int ONLINE_BIT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             autocfg_dis,
  input  logic             cfg_grant,
  input  logic             cfg_ack_n,
  input  logic             bist_done,
  input  logic             bist_pass,
  input  logic [CFG_W-1:0] cfg_bits,
  output seq_state_t       state,
  output logic             load_dflt,
  output logic             load_data,
  output logic             fail_set
);
  seq_state_t nxt;
  logic       keep_on;

  assign keep_on = bist_pass | cfg_bits[ONLINE_BIT];

  always_comb begin
    nxt       = state;
    load_dflt = 1'b0;
    load_data = 1'b0;
    fail_set  = 1'b0;
    unique case (state)
      ST_RESET: begin
        if (autocfg_dis) begin
          load_dflt = 1'b1;
          nxt       = ST_BIST;
        end else begin
          nxt = ST_CFG_REQ;
        end
      end
      ST_CFG_REQ: begin
        if (cfg_grant) nxt = ST_CFG_ACK;
      end
      ST_CFG_ACK: begin
        if (!cfg_ack_n) begin
          load_data = 1'b1;
          nxt       = ST_BIST;
        end
      end
      ST_BIST: begin
        if (bist_done) begin
          fail_set = ~bist_pass;
          nxt      = keep_on ? ST_ONLINE : ST_OFFLINE;
        end
      end
      ST_ONLINE:  nxt = ST_ONLINE;
      ST_OFFLINE: nxt = ST_OFFLINE;
      default:    nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RESET;
    else     state <= nxt;
  end
endmodule

// File: rtl/pwr_cfg_reg.sv
module pwr_cfg_reg #(
  parameter int CFG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_dflt,
  input  logic             load_data,
  input  logic [CFG_W-1:0] data,
  output logic [CFG_W-1:0] cfg
);
  localparam logic [CFG_W-1:0] DFLT = {CFG_W{1'b1}};

  for (genvar i = 0; i < CFG_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)            cfg[i] <= 1'b0;
      else if (load_dflt) cfg[i] <= DFLT[i];
      else if (load_data) cfg[i] <= data[i];
    end
  end
endmodule

// File: rtl/pwr_out_stage.sv
module pwr_out_stage
  import pwr_seq_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_t        state,
  input  logic              fail_set,
  input  logic              tx_inhibit,
  output logic              active,
  output logic              cfg_req,
  output logic              bist_start,
  output logic              rt_fail_n,
  output logic [NUM_CH-1:0] tx_en
);
  assign active     = (state == ST_ONLINE);
  assign cfg_req    = (state == ST_CFG_REQ);
  assign bist_start = (state == ST_BIST);

  always_ff @(posedge clk) begin
    if (rst)           rt_fail_n <= 1'b1;
    else if (fail_set) rt_fail_n <= 1'b0;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign tx_en[c] = active & ~tx_inhibit;
  end
endmodule

// File: rtl/pwrup_cfg_seq.sv
module pwrup_cfg_seq
  import pwr_seq_pkg::*;
#(
  parameter int CFG_W       = 6,
  parameter int ONLINE_BIT  = 5,
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              mclr_n,
  input  logic              autocfg_dis,
  output logic              cfg_req,
  input  logic              cfg_grant,
  input  logic              cfg_ack_n,
  input  logic [CFG_W-1:0]  cfg_data,
  output logic              bist_start,
  input  logic              bist_done,
  input  logic              bist_pass,
  input  logic              tx_inhibit,
  output logic              active,
  output logic              rt_fail_n,
  output logic [CFG_W-1:0]  cfg_bits,
  output logic [NUM_CH-1:0] tx_en
);
  logic       rst;
  seq_state_t state;
  logic       load_dflt, load_data, fail_set;

  pwr_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .async_n(mclr_n), .rst(rst)
  );

  pwr_seq_fsm #(.CFG_W(CFG_W), .ONLINE_BIT(ONLINE_BIT)) u_fsm (
    .clk(clk), .rst(rst), .autocfg_dis(autocfg_dis),
    .cfg_grant(cfg_grant), .cfg_ack_n(cfg_ack_n),
    .bist_done(bist_done), .bist_pass(bist_pass),
    .cfg_bits(cfg_bits), .state(state),
    .load_dflt(load_dflt), .load_data(load_data), .fail_set(fail_set)
  );

  pwr_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .load_dflt(load_dflt), .load_data(load_data),
    .data(cfg_data), .cfg(cfg_bits)
  );

  pwr_out_stage #(.NUM_CH(NUM_CH)) u_out (
    .clk(clk), .rst(rst), .state(state), .fail_set(fail_set),
    .tx_inhibit(tx_inhibit), .active(active), .cfg_req(cfg_req),
    .bist_start(bist_start), .rt_fail_n(rt_fail_n), .tx_en(tx_en)
  );
endmodule

// File: rtl/pwrup_cfg_seq_chk.sv
module pwrup_cfg_seq_chk #(
  parameter int CFG_W      = 6,
  parameter int ONLINE_BIT = 5,
  parameter int NUM_CH     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              active,
  input logic              rt_fail_n,
  input logic              cfg_req,
  input logic              bist_start,
  input logic              bist_done,
  input logic              bist_pass,
  input logic              tx_inhibit,
  input logic [CFG_W-1:0]  cfg_bits,
  input logic [NUM_CH-1:0] tx_en
);
  // R1
  idle_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_req || bist_start) |-> !active);

  // R2
  clear_drops_active_chk: assert property (@(posedge clk)
    rst |=> (!active && rt_fail_n));

  // R6
  online_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(bist_done && (bist_pass || cfg_bits[ONLINE_BIT])));

  // R7
  fail_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rt_fail_n) |-> $past(bist_start && bist_done && !bist_pass));

  // R8
  online_hold_chk: assert property (@(posedge clk) disable iff (rst)
    active |=> active);

  // R8
  fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rt_fail_n |=> !rt_fail_n);

  // R9
  tx_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en != '0) |-> (active && !tx_inhibit));
endmodule

bind pwrup_cfg_seq pwrup_cfg_seq_chk #(
  .CFG_W(CFG_W), .ONLINE_BIT(ONLINE_BIT), .NUM_CH(NUM_CH)
) u_chk (
  .clk(clk), .rst(rst), .active(active), .rt_fail_n(rt_fail_n),
  .cfg_req(cfg_req), .bist_start(bist_start), .bist_done(bist_done),
  .bist_pass(bist_pass), .tx_inhibit(tx_inhibit), .cfg_bits(cfg_bits),
  .tx_en(tx_en)
);

// File: tb/sim_pwrup_cfg_seq.sv
`timescale 1ns/1ps
module sim_pwrup_cfg_seq;
  logic       clk = 1'b0;
  logic       mclr_n = 1'b0;
  logic       autocfg_dis = 1'b0;
  logic       cfg_grant = 1'b0;
  logic       cfg_ack_n = 1'b1;
  logic [5:0] cfg_data = 6'h00;
  logic       bist_done = 1'b0;
  logic       bist_pass = 1'b0;
  logic       tx_inhibit = 1'b0;
  logic       cfg_req, bist_start, active, rt_fail_n;
  logic [5:0] cfg_bits;
  logic [1:0] tx_en;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done_run = 1'b0;

  always #10 clk = ~clk;

  pwrup_cfg_seq u0 (
    .clk(clk), .mclr_n(mclr_n), .autocfg_dis(autocfg_dis),
    .cfg_req(cfg_req), .cfg_grant(cfg_grant), .cfg_ack_n(cfg_ack_n),
    .cfg_data(cfg_data), .bist_start(bist_start), .bist_done(bist_done),
    .bist_pass(bist_pass), .tx_inhibit(tx_inhibit), .active(active),
    .rt_fail_n(rt_fail_n), .cfg_bits(cfg_bits), .tx_en(tx_en)
  );

  // Behavioural reference: phase 0 idle, 1 requesting, 2 awaiting ack,
  // 3 self-test, 4 on-line, 5 off-line.
  int   m_ph = 0;
  logic m_q1 = 1'b0, m_q2 = 1'b0;
  logic [5:0] m_cfg = 6'h00;
  logic m_fail = 1'b0;

  always @(posedge clk) begin
    cycles++;
    if (!m_q2) begin
      m_ph = 0; m_cfg = 6'h00; m_fail = 1'b0;
    end else begin
      case (m_ph)
        0: if (autocfg_dis) begin m_cfg = 6'h3f; m_ph = 3; end else m_ph = 1;
        1: if (cfg_grant) m_ph = 2;
        2: if (!cfg_ack_n) begin m_cfg = cfg_data; m_ph = 3; end
        3: if (bist_done) begin
             if (!bist_pass) m_fail = 1'b1;
             m_ph = (bist_pass || m_cfg[5]) ? 4 : 5;
           end
        default: ;
      endcase
    end
    m_q2 = m_q1;
    m_q1 = mclr_n;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (!done_run) begin
      chk("R1", "active", active, m_ph == 4);
      chk("R7", "rt_fail_n", rt_fail_n, !m_fail);
      chk("R4", "cfg_req", cfg_req, m_ph == 1);
      chk("R10", "bist_start", bist_start, m_ph == 3);
      chk("R5", "cfg_bits", cfg_bits, m_cfg);
      chk("R9", "tx_en", tx_en, {2{(m_ph == 4) && !tx_inhibit}});
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_high(ref logic s);
    for (int i = 0; i < 40 && !s; i++) @(negedge clk);
  endtask

  task automatic run_case(input logic dis, input logic [5:0] word,
                          input logic pass, input logic early_ack);
    @(negedge clk);
    mclr_n = 1'b0;
    autocfg_dis = dis;
    cyc(4);
    chk("R2", "reset active", active, 0);
    chk("R2", "reset rt_fail_n", rt_fail_n, 1);
    mclr_n = 1'b1;
    if (!dis) begin
      wait_high(cfg_req);
      cyc(2);
      if (early_ack) begin
        cfg_ack_n = 1'b0; cfg_data = ~word; cyc(1); // R4 ignored before grant
        cfg_ack_n = 1'b1;
      end
      cfg_grant = 1'b1; cyc(1); cfg_grant = 1'b0;
      cyc(2);
      cfg_ack_n = 1'b0; cfg_data = word; cyc(1);
      cfg_ack_n = 1'b1; cfg_data = ~word;
    end
    wait_high(bist_start);
    cyc(3);
    bist_done = 1'b1; bist_pass = pass; cyc(1);
    bist_done = 1'b0;
    cyc(3);
    tx_inhibit = 1'b1; cyc(2); tx_inhibit = 1'b0; cyc(1);
    // R8: late self-test pulse with opposite verdict has no effect
    bist_done = 1'b1; bist_pass = !pass; cyc(1);
    bist_done = 1'b0;
    cfg_grant = 1'b1; cfg_ack_n = 1'b0; cyc(2);
    cfg_grant = 1'b0; cfg_ack_n = 1'b1;
    cyc(3);
  endtask

  initial begin
    cyc(3);
    chk("R2", "initial active", active, 0);
    run_case(1'b1, 6'h00, 1'b1, 1'b0); // R3 defaults, pass
    run_case(1'b0, 6'h2a, 1'b0, 1'b0); // R6 bit5 rescues a failure
    run_case(1'b0, 6'h15, 1'b0, 1'b1); // R7 off-line, early ack
    run_case(1'b0, 6'h15, 1'b1, 1'b0); // R6 pass on-line
    run_case(1'b1, 6'h00, 1'b0, 1'b0); // R3 skipped config, failure
    run_case(1'b0, 6'h00, 1'b0, 1'b1); // R7 all-zero word off-line
    done_run = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done_run) begin
      done_run = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule